// File: doc/BRIEF.md
# Baudot keyboard shift encoder

This block turns 7-bit ASCII keystrokes into the 5-bit Baudot codes that a keyboard-input device hands to a processor. Baudot has two cases, letters and figures, and the same 5-bit code means different characters in each. The encoder keeps the current case in a shift flag. When a keystroke belongs to the other case, it first delivers the matching case-change code and updates the flag. It keeps the real character in a one-entry pending register, and that character goes out in the next delivery slot before any new keystroke.

Keystrokes arrive on a valid/ready input. Each delivered code is placed in an output register and a done flag is raised. The consumer polls the flag, takes the code, and issues a read/clear pulse, which frees the slot for the next delivery. The shift flag is brought out so the printer side of the same terminal can follow the current case. The translation table is computed inside the block. Lowercase letters fold onto uppercase, and keys with no Baudot equivalent are dropped.

Top module: `baudot_kbd_encoder`

## Requirements
- R1: After reset, code_out is 0, done is 0, shift_figs is 0 (letters case) and key_ready is 1, and no delayed character is delivered afterwards.
- R2: A keystroke whose table case matches shift_figs (1 = figures) is delivered as a single code on the clock edge that accepts it, with done set: 'A' gives octal 030 and 'T' gives 01 in letters case, and '5' gives 01 in figures case.
- R3: A key with no table entry (for example '%' 0x25, '@' 0x40 or NUL) is accepted and dropped: done stays 0, shift_figs keeps its value and key_ready stays 1.
- R4: A keystroke of the other case first delivers the case-change code, octal 033 to enter figures or 037 to enter letters, and shift_figs takes the new case on that same edge; '0' typed in letters case gives 033 followed by 015.
- R5: The real code of a case-changing keystroke is held pending and delivered on the first edge after done has been cleared, ahead of any new keystroke; key_ready is 0 while a code is pending.
- R6: Lowercase keys 0x60 to 0x7F give exactly the same code sequence as the keys 0x40 to 0x5F, in either case state.
- R7: Space (04), carriage return (02) and line feed (010) are delivered directly in either case and never change shift_figs.
- R8: rd_clear while done is 1 clears done on the next edge, and key_ready is 1 exactly when done is 0 and no code is pending.
- R9: While done is 1 and rd_clear is 0, code_out and done hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Keystroke offered |
| key_data | input | CHAR_W | ASCII keystroke |
| key_ready | output | 1 | Keystroke accepted when valid and ready |
| rd_clear | input | 1 | Read/clear command; drops done |
| code_out | output | 5 | Last delivered Baudot code |
| done | output | 1 | A delivered code awaits reading |
| shift_figs | output | 1 | Current case, 1 = figures, shared with the printer side |

## Verification
The checker watches the slot protocol on every cycle. It checks that done blocks key_ready, that a held code stays stable until it is read, that a read clears done, and that a waiting pending code goes out at the next free slot. It also checks that every change of shift_figs comes with the matching case-change code on code_out. The translation contents can only be shown by the bench's scenarios: the stated codes, the dropped keys, both-case control codes, and the sweep that compares every lowercase key with its uppercase counterpart from each case state. The same applies to the priority of a pending code over a keystroke that is held valid through the pending slot.

// File: rtl/bd_pkg.sv
package bd_pkg;
   localparam int BD_CODE_W = 5;
   localparam int BD_IDX_W  = 7;

   typedef logic [BD_CODE_W-1:0] bd_code_t;

   // table entry: both-case flag, figures flag, 5-bit code
   typedef struct packed {
      logic     both;
      logic     figs;
      bd_code_t code;
   } bd_entry_t;
endpackage

// File: rtl/bd_rom.sv
module bd_rom #(
   parameter int CHAR_W    = 7,
   parameter bit FOLD_CASE = 1'b1
) (
   input  logic [CHAR_W-1:0] key,
   output bd_pkg::bd_entry_t entry
);
   localparam int IW = bd_pkg::BD_IDX_W;

   logic [IW-1:0] base;
   logic [IW-1:0] idx;
   logic          in_range;
   logic [IW-1:0] raw;

   assign base = key[IW-1:0];

   generate
      if (CHAR_W > IW) begin : g_wide
         assign in_range = ~|key[CHAR_W-1:IW];
      end else begin : g_exact
         assign in_range = 1'b1;
      end
   endgenerate

   generate
      if (FOLD_CASE) begin : g_fold
         assign idx = (base[6:5] == 2'b11) ? {2'b10, base[4:0]} : base;
      end else begin : g_nofold
         assign idx = base;
      end
   endgenerate

   // {both, figs, code[4:0]} written in octal
   always_comb begin
      case (idx)
         7'h07: raw = 7'o064;
         7'h0A: raw = 7'o110;
         7'h0D: raw = 7'o102;
         7'h20: raw = 7'o104;
         7'h21: raw = 7'o066;
         7'h22: raw = 7'o061;
         7'h23: raw = 7'o045;
         7'h24: raw = 7'o062;
         7'h26: raw = 7'o053;
         7'h27: raw = 7'o072;
         7'h28: raw = 7'o076;
         7'h29: raw = 7'o051;
         7'h2C: raw = 7'o046;
         7'h2D: raw = 7'o070;
         7'h2E: raw = 7'o047;
         7'h2F: raw = 7'o067;
         7'h30: raw = 7'o055;
         7'h31: raw = 7'o075;
         7'h32: raw = 7'o071;
         7'h33: raw = 7'o060;
         7'h34: raw = 7'o052;
         7'h35: raw = 7'o041;
         7'h36: raw = 7'o065;
         7'h37: raw = 7'o074;
         7'h38: raw = 7'o054;
         7'h39: raw = 7'o043;
         7'h3A: raw = 7'o056;
         7'h3B: raw = 7'o057;
         7'h3F: raw = 7'o063;
         7'h41: raw = 7'o030;
         7'h42: raw = 7'o023;
         7'h43: raw = 7'o016;
         7'h44: raw = 7'o022;
         7'h45: raw = 7'o020;
         7'h46: raw = 7'o026;
         7'h47: raw = 7'o013;
         7'h48: raw = 7'o005;
         7'h49: raw = 7'o014;
         7'h4A: raw = 7'o032;
         7'h4B: raw = 7'o036;
         7'h4C: raw = 7'o011;
         7'h4D: raw = 7'o007;
         7'h4E: raw = 7'o006;
         7'h4F: raw = 7'o003;
         7'h50: raw = 7'o015;
         7'h51: raw = 7'o035;
         7'h52: raw = 7'o012;
         7'h53: raw = 7'o024;
         7'h54: raw = 7'o001;
         7'h55: raw = 7'o034;
         7'h56: raw = 7'o017;
         7'h57: raw = 7'o031;
         7'h58: raw = 7'o027;
         7'h59: raw = 7'o025;
         7'h5A: raw = 7'o021;
         default: raw = 7'o000;
      endcase
   end

   assign entry = in_range ? bd_pkg::bd_entry_t'(raw) : '0;
endmodule

// File: rtl/bd_shift_ctl.sv
module bd_shift_ctl #(
   parameter logic [4:0] FIGS_SHIFT = 5'o33,
   parameter logic [4:0] LTRS_SHIFT = 5'o37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_free,
   input  logic              key_fire,
   input  bd_pkg::bd_entry_t entry,
   output logic              emit,
   output bd_pkg::bd_code_t  emit_code,
   output logic              shift_q,
   output logic              pend_q
);
   bd_pkg::bd_code_t pend_code_q;
   logic             known;
   logic             direct;

   assign known  = (entry != '0);
   assign direct = entry.both || (entry.figs == shift_q);

   always_comb begin
      emit      = 1'b0;
      emit_code = '0;
      if (pend_q && slot_free) begin
         emit      = 1'b1;
         emit_code = pend_code_q;
      end else if (key_fire && known) begin
         emit = 1'b1;
         if (direct) emit_code = entry.code;
         else        emit_code = entry.figs ? FIGS_SHIFT : LTRS_SHIFT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shift_q     <= 1'b0;
         pend_q      <= 1'b0;
         pend_code_q <= '0;
      end else if (pend_q && slot_free) begin
         pend_q <= 1'b0;
      end else if (key_fire && known && !direct) begin
         shift_q     <= entry.figs;
         pend_code_q <= entry.code;
         pend_q      <= 1'b1;
      end
   end
endmodule

// File: rtl/bd_out_reg.sv
module bd_out_reg (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  bd_pkg::bd_code_t load_code,
   input  logic             clear,
   output bd_pkg::bd_code_t code_q,
   output logic             done_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         done_q <= 1'b0;
      end else if (load) begin
         code_q <= load_code;
         done_q <= 1'b1;
      end else if (clear) begin
         done_q <= 1'b0;
      end
   end
endmodule

// File: rtl/baudot_kbd_encoder.sv
module baudot_kbd_encoder #(
   parameter int         CHAR_W     = 7,
   parameter bit         FOLD_CASE  = 1'b1,
   parameter logic [4:0] FIGS_SHIFT = 5'o33,
   parameter logic [4:0] LTRS_SHIFT = 5'o37
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_data,
   output logic              key_ready,
   input  logic              rd_clear,
   output logic [4:0]        code_out,
   output logic              done,
   output logic              shift_figs
);
   generate
      if (CHAR_W < bd_pkg::BD_IDX_W) begin : g_bad_width
         $error("CHAR_W must cover 7-bit ASCII");
      end
      if (FIGS_SHIFT == LTRS_SHIFT) begin : g_bad_shift
         $error("case-change codes must differ");
      end
   endgenerate

   bd_pkg::bd_entry_t entry;
   bd_pkg::bd_code_t  emit_code;
   logic              emit;
   logic              pend_valid;
   logic              key_fire;

   assign key_ready = !done && !pend_valid;
   assign key_fire  = key_valid && key_ready;

   bd_rom #(.CHAR_W(CHAR_W), .FOLD_CASE(FOLD_CASE)) u_rom (
      .key   (key_data),
      .entry (entry)
   );

   bd_shift_ctl #(.FIGS_SHIFT(FIGS_SHIFT), .LTRS_SHIFT(LTRS_SHIFT)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_free (!done),
      .key_fire  (key_fire),
      .entry     (entry),
      .emit      (emit),
      .emit_code (emit_code),
      .shift_q   (shift_figs),
      .pend_q    (pend_valid)
   );

   bd_out_reg u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (emit),
      .load_code (emit_code),
      .clear     (rd_clear),
      .code_q    (code_out),
      .done_q    (done)
   );
endmodule

module bd_enc_checker #(
   parameter logic [4:0] FIGS_SHIFT = 5'o33,
   parameter logic [4:0] LTRS_SHIFT = 5'o37
) (
   input logic       clk,
   input logic       rst_n,
   input logic       done,
   input logic       rd_clear,
   input logic       key_ready,
   input logic [4:0] code_out,
   input logic       shift_figs,
   input logic       pend_valid
);
   // R8
   ready_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || pend_valid) |-> !key_ready);

   // R8
   clear_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_clear) |=> !done);

   // R9
   hold_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd_clear) |=> (done && $stable(code_out)));

   // R4
   shift_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shift_figs) |-> (done && code_out == (shift_figs ? FIGS_SHIFT : LTRS_SHIFT)));

   // R5
   pending_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && !done) |=> (done && !pend_valid));
endmodule

bind baudot_kbd_encoder bd_enc_checker #(.FIGS_SHIFT(FIGS_SHIFT), .LTRS_SHIFT(LTRS_SHIFT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done       (done),
   .rd_clear   (rd_clear),
   .key_ready  (key_ready),
   .code_out   (code_out),
   .shift_figs (shift_figs),
   .pend_valid (pend_valid)
);

// File: tb/tb_baudot_kbd_encoder.sv
module tb_baudot_kbd_encoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_valid = 1'b0;
   logic [6:0] key_data = '0;
   logic       rd_clear = 1'b0;
   logic       key_ready;
   logic [4:0] code_out;
   logic       done;
   logic       shift_figs;

   int errors = 0;
   int checks = 0;

   localparam logic [4:0] FIG = 5'o33;
   localparam logic [4:0] LTR = 5'o37;

   always #2.5 clk = ~clk;

   baudot_kbd_encoder dut (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_data(key_data),
      .key_ready(key_ready), .rd_clear(rd_clear), .code_out(code_out),
      .done(done), .shift_figs(shift_figs)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0o expected=%0o", req, act, exp);
      end
   endtask

   // offer one key, then read out every code it produces
   task automatic press(input logic [6:0] c, output int n, output logic [4:0] c0,
                        output logic [4:0] c1, output logic rdy_mid);
      n = 0; c0 = '0; c1 = '0; rdy_mid = 1'b1;
      while (!key_ready) @(negedge clk);
      key_valid = 1'b1; key_data = c;
      @(negedge clk);
      key_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         if (done) begin
            if (n == 0) c0 = code_out; else c1 = code_out;
            n++;
            rd_clear = 1'b1;
            @(negedge clk);
            rd_clear = 1'b0;
            if (n == 1) rdy_mid = key_ready;
            @(negedge clk);
         end
      end
   endtask

   task automatic set_case(input logic f);
      int n; logic [4:0] a, b; logic r;
      if (shift_figs != f) press(f ? 7'h35 : 7'h41, n, a, b, r);
   endtask

   task automatic pulse_reset();
      rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      int n, nl;
      logic [4:0] c0, c1, l0, l1;
      logic r, rl, sh;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(code_out == 0 && !done, "R1 code/done", {code_out, done}, 0);
      chk(shift_figs == 0 && key_ready, "R1 shift/ready", {shift_figs, key_ready}, 1);

      // R2 direct letters
      press(7'h41, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o30 && !shift_figs, "R2 A", c0, 5'o30);
      press(7'h54, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o01, "R2 T", c0, 5'o01);

      // R4 R5 case change to figures
      press(7'h30, n, c0, c1, r);
      chk(n == 2 && c0 == FIG, "R4 figures shift", c0, FIG);
      chk(c1 == 5'o15 && shift_figs, "R5 pending zero", c1, 5'o15);
      chk(r == 1'b0, "R5 ready low while pending", r, 0);
      press(7'h35, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o01, "R2 five in figures", c0, 5'o01);

      // R7 both-case codes in figures then letters
      press(7'h20, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o04 && shift_figs, "R7 space figs", c0, 5'o04);
      press(7'h0D, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o02 && shift_figs, "R7 CR figs", c0, 5'o02);
      press(7'h0A, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o10 && shift_figs, "R7 LF figs", c0, 5'o10);

      // R4 R6 lowercase returns to letters
      press(7'h61, n, c0, c1, r);
      chk(n == 2 && c0 == LTR && c1 == 5'o30 && !shift_figs, "R4 letters shift", c0, LTR);
      press(7'h20, n, c0, c1, r);
      chk(n == 1 && c0 == 5'o04 && !shift_figs, "R7 space letters", c0, 5'o04);

      // R3 dropped keys in both states
      for (int f = 0; f < 2; f++) begin
         set_case(f[0]);
         press(7'h25, n, c0, c1, r);
         chk(n == 0 && !done && shift_figs == f[0] && key_ready, "R3 percent", n, 0);
         press(7'h40, n, c0, c1, r);
         chk(n == 0 && !done && shift_figs == f[0], "R3 at-sign", n, 0);
         press(7'h00, n, c0, c1, r);
         chk(n == 0 && !done && shift_figs == f[0], "R3 NUL", n, 0);
      end

      // R5 R8 R9 pending beats a key held valid
      set_case(1'b0);
      @(negedge clk);
      key_valid = 1'b1; key_data = 7'h30;
      @(negedge clk);
      key_data = 7'h54;
      chk(done && code_out == FIG && !key_ready, "R8 ready low with done", code_out, FIG);
      @(negedge clk);
      chk(done && code_out == FIG, "R9 held until read", code_out, FIG);
      rd_clear = 1'b1;
      @(negedge clk);
      rd_clear = 1'b0;
      chk(!done && !key_ready, "R8 done cleared, pending blocks", {done, key_ready}, 0);
      @(negedge clk);
      chk(done && code_out == 5'o15, "R5 pending before new key", code_out, 5'o15);
      rd_clear = 1'b1;
      @(negedge clk);
      rd_clear = 1'b0;
      @(negedge clk);
      key_valid = 1'b0;
      chk(done && code_out == LTR, "R4 held key then shifts", code_out, LTR);
      rd_clear = 1'b1;
      @(negedge clk);
      rd_clear = 1'b0;
      @(negedge clk);
      chk(done && code_out == 5'o01 && !shift_figs, "R5 T follows", code_out, 5'o01);
      rd_clear = 1'b1;
      @(negedge clk);
      rd_clear = 1'b0;
      @(negedge clk);

      // R1 reset while a code is pending
      key_valid = 1'b1; key_data = 7'h31;
      @(negedge clk);
      key_valid = 1'b0;
      pulse_reset();
      chk(!done && code_out == 0 && !shift_figs && key_ready, "R1 reset clears pending",
          {done, code_out, shift_figs}, 0);
      @(negedge clk); @(negedge clk);
      chk(!done, "R1 no late delivery", done, 0);

      // R6 sweep of lowercase against uppercase in both states
      for (int f = 0; f < 2; f++) begin
         for (int i = 0; i < 32; i++) begin
            set_case(f[0]);
            press(7'(7'h40 + i), n, c0, c1, r);
            sh = shift_figs;
            set_case(f[0]);
            press(7'(7'h60 + i), nl, l0, l1, rl);
            chk(n == nl && c0 == l0 && (n < 2 || c1 == l1) && sh == shift_figs,
                "R6 fold", {nl, l0, l1}, {n, c0, c1});
            if (n == 2)
               chk(c0 == (sh ? FIG : LTR) && sh != f[0], "R4 sweep shift", c0, sh ? FIG : LTR);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule